// File: doc/BRIEF.md
# Interrupt steering aggregator

This block concentrates a wide set of level-sensitive interrupt lines into a small number of output interrupts. The inputs are grouped into 32-bit banks. Each input has its own enable bit and its own software-force bit. Every group of 64 consecutive inputs is reduced to one output line. A single one-hot channel word selects whether this instance's channel is live. A master disable bit can silence every output at once.

Software reaches all state through a plain 32-bit register port: byte address, write strobe, write data and registered read data. It reads the pending-and-enabled status of each bank and a per-group summary word. Inputs cross into the clock domain through a two-flop synchroniser. Outputs are registered.

Top module: `irq_steer`

## Requirements
- R1: A synchronous reset clears the channel, enable, force and disable state, drives every output interrupt low and returns zero read data on the cycle after reset.
- R2: With R = N_IN/32 banks, the register word layout is as follows. Channel word at byte 0x0 reads back all 32 bits written. Enable word i is at 0x4+4i and force word i is at 4R+0x4+4i; both read back as written. The disable word at 12R+0x4 keeps and returns only bit 0. Read data appears one clock after the address is presented.
- R3: Inputs 32k to 32k+31 belong to word index R-1-k of the enable, force and status words, so the highest word holds inputs 0 to 31. The bit position inside the word is the input number mod 32.
- R4: Status word i, at 8R+0x4+4i, returns for each bit the synchronised input level ORed with its force bit, ANDed with its enable bit (1 = enabled). Status follows the level two clocks after an input changes, with no clear-on-read.
- R5: A force bit written 1 makes its input pending, regardless of the external level, until software writes it back to 0.
- R6: Output j is the OR of the enabled pending inputs 64j to 64j+63. It is registered: it changes one clock after the enable or force write, and three clocks after an input change.
- R7: The outputs stay low whenever bit CHAN_SEL of the channel word is 0.
- R8: Bit 0 of the disable word, when 1, forces every output low and leaves the status words and the summary word unchanged.
- R9: The summary word at 12R+0x8 has bit j set to the OR of the enabled pending inputs in group j, ahead of the disable and channel gating.
- R10: Writes to status words, to the summary word or to unmapped offsets change no state. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IN | Level-sensitive interrupt inputs, asynchronous |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | ceil(N_IN/64) | Per-group output interrupts |

## Verification
A wrong enable or force bit, or a bank stored in the wrong word, shows up two ways. Within one clock the affected output rises or fails to rise. Reading that bank's status word gives the wrong bit, or the right bit in the wrong word. A broken synchroniser or output register shows up as an output edge one clock early or late against the three-clock input path. The reference model therefore compares outputs and read data on every clock. Stray state from ignored writes only surfaces when the enable, force and status words are read back later.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int BANK_W  = 32;
  localparam int GROUP_W = 64;
  localparam int MAX_OUT = 8;

  typedef enum logic [2:0] {
    REG_CTRL,
    REG_MASK,
    REG_SET,
    REG_STAT,
    REG_MDIS,
    REG_MSTAT,
    REG_NONE
  } reg_kind_e;

  function automatic int out_count(input int n_in);
    return (n_in + GROUP_W - 1) / GROUP_W;
  endfunction

  function automatic int idx_width(input int n_words);
    return (n_words > 1) ? $clog2(n_words) : 1;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/steer_decode.sv
module steer_decode
  import irq_steer_pkg::*;
#(
  parameter int NW     = 4,
  parameter int ADDR_W = 12,
  localparam int IDXW  = idx_width(NW)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDXW-1:0]   idx
);
  logic [31:0] word;
  logic        unused_lsb;

  assign unused_lsb = ^addr[1:0];
  assign word       = 32'(addr[ADDR_W-1:2]);

  always_comb begin
    kind = REG_NONE;
    idx  = '0;
    if (word == 32'd0) begin
      kind = REG_CTRL;
    end else if (word <= 32'(NW)) begin
      kind = REG_MASK;
      idx  = IDXW'(word - 32'd1);
    end else if (word <= 32'(2 * NW)) begin
      kind = REG_SET;
      idx  = IDXW'(word - 32'd1 - 32'(NW));
    end else if (word <= 32'(3 * NW)) begin
      kind = REG_STAT;
      idx  = IDXW'(word - 32'd1 - 32'(2 * NW));
    end else if (word == 32'(3 * NW + 1)) begin
      kind = REG_MDIS;
    end else if (word == 32'(3 * NW + 2)) begin
      kind = REG_MSTAT;
    end
  end
endmodule

// File: rtl/steer_regs.sv
module steer_regs
  import irq_steer_pkg::*;
#(
  parameter int NW    = 4,
  localparam int IDXW = idx_width(NW)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  reg_kind_e               kind,
  input  logic [IDXW-1:0]         idx,
  input  logic [BANK_W-1:0]       wdata,
  output logic [BANK_W-1:0]       ctrl_q,
  output logic                    dis_q,
  output logic [NW-1:0][BANK_W-1:0] mask_q,
  output logic [NW-1:0][BANK_W-1:0] set_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      dis_q  <= 1'b0;
    end else if (wr_en) begin
      if (kind == REG_CTRL) ctrl_q <= wdata;
      if (kind == REG_MDIS) dis_q  <= wdata[0];
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_word
    logic hit;
    assign hit = wr_en && (idx == IDXW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[i] <= '0;
        set_q[i]  <= '0;
      end else begin
        if (hit && kind == REG_MASK) mask_q[i] <= wdata;
        if (hit && kind == REG_SET)  set_q[i]  <= wdata;
      end
    end
  end
endmodule

// File: rtl/group_reduce.sv
module group_reduce
  import irq_steer_pkg::*;
#(
  parameter int N  = 128,
  parameter int NG = out_count(N)
) (
  input  logic [N-1:0]  pend,
  output logic [NG-1:0] grp
);
  for (genvar j = 0; j < NG; j++) begin : g_grp
    localparam int LO = j * GROUP_W;
    localparam int HI = ((LO + GROUP_W) < N) ? (LO + GROUP_W - 1) : (N - 1);
    assign grp[j] = |pend[HI:LO];
  end
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_steer_pkg::*;
#(
  parameter int N_IN     = 128,
  parameter int ADDR_W   = 12,
  parameter int CHAN_SEL = 1,
  localparam int NW      = N_IN / BANK_W,
  localparam int NOUT    = out_count(N_IN),
  localparam int IDXW    = idx_width(NW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NOUT-1:0]   irq_out
);
  reg_kind_e                  kind;
  logic [IDXW-1:0]            idx;
  logic [N_IN-1:0]            lvl;
  logic [BANK_W-1:0]          ctrl_q;
  logic                       dis_q;
  logic [NW-1:0][BANK_W-1:0]  mask_q;
  logic [NW-1:0][BANK_W-1:0]  set_q;
  logic [NW-1:0][BANK_W-1:0]  pend_w;
  logic [N_IN-1:0]            en_vec;
  logic [N_IN-1:0]            set_vec;
  logic [N_IN-1:0]            pend;
  logic [NOUT-1:0]            grp;
  logic                       stat_wr;
  logic [31:0]                rd_val;

  irq_sync #(.W(N_IN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_in),
    .q   (lvl)
  );

  steer_decode #(.NW(NW), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .kind (kind),
    .idx  (idx)
  );

  steer_regs #(.NW(NW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_we),
    .kind   (kind),
    .idx    (idx),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q),
    .dis_q  (dis_q),
    .mask_q (mask_q),
    .set_q  (set_q)
  );

  // bank b (inputs 32b..32b+31) lives in word NW-1-b
  for (genvar b = 0; b < NW; b++) begin : g_bank
    assign en_vec[b*BANK_W +: BANK_W]  = mask_q[NW-1-b];
    assign set_vec[b*BANK_W +: BANK_W] = set_q[NW-1-b];
    assign pend_w[NW-1-b]              = pend[b*BANK_W +: BANK_W];
  end

  assign pend    = (lvl | set_vec) & en_vec;
  assign stat_wr = bus_we && (kind == REG_STAT);

  group_reduce #(.N(N_IN), .NG(NOUT)) u_red (
    .pend (pend),
    .grp  (grp)
  );

  always_comb begin
    case (kind)
      REG_CTRL:  rd_val = ctrl_q;
      REG_MASK:  rd_val = mask_q[idx];
      REG_SET:   rd_val = set_q[idx];
      REG_STAT:  rd_val = pend_w[idx];
      REG_MDIS:  rd_val = {31'd0, dis_q};
      REG_MSTAT: rd_val = 32'(grp);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= '0;
    end else begin
      bus_rdata <= rd_val;
      irq_out   <= (dis_q || !ctrl_q[CHAN_SEL]) ? '0 : grp;
    end
  end
endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
  parameter int N_IN     = 128,
  parameter int NOUT     = 2,
  parameter int CHAN_SEL = 1
) (
  input logic            clk,
  input logic            rst,
  input logic [NOUT-1:0] irq_out,
  input logic [31:0]     bus_rdata,
  input logic [31:0]     ctrl_q,
  input logic            dis_q,
  input logic [NOUT-1:0] grp,
  input logic            stat_wr,
  input logic [N_IN-1:0] en_vec,
  input logic [N_IN-1:0] set_vec
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && bus_rdata == 32'd0));

  // R7
  chan_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CHAN_SEL] |=> (irq_out == '0));

  // R8
  master_dis_chk: assert property (@(posedge clk) disable iff (rst)
    dis_q |=> (irq_out == '0));

  // R9
  out_implies_group_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> (($past(grp) & irq_out) == irq_out));

  // R10
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> ($stable(en_vec) && $stable(set_vec)));
endmodule

bind irq_steer steer_chk #(.N_IN(N_IN), .NOUT(NOUT), .CHAN_SEL(CHAN_SEL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_out   (irq_out),
  .bus_rdata (bus_rdata),
  .ctrl_q    (ctrl_q),
  .dis_q     (dis_q),
  .grp       (grp),
  .stat_wr   (stat_wr),
  .en_vec    (en_vec),
  .set_vec   (set_vec)
);

// File: tb/irq_steer_test.sv
module irq_steer_test;
  localparam int CLK_NS = 10;
  localparam int NI     = 128;
  localparam int NB     = NI / 32;
  localparam int NO     = (NI + 63) / 64;
  localparam int CH     = 1;
  localparam int AW     = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NI-1:0] irq_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NO-1:0] irq_out;

  int total = 0;
  int bad   = 0;
  bit started = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  irq_steer #(.N_IN(NI), .ADDR_W(AW), .CHAN_SEL(CH)) uut (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  // behavioural reference, indexed by input number
  logic [NI-1:0] m_en, m_force, m_s1, m_s2;
  logic [31:0]   m_ctrl;
  logic          m_dis;
  logic [NO-1:0] e_out;
  logic [31:0]   e_rd;
  string         e_tag;

  function automatic logic m_pend(input int n);
    return (m_s2[n] | m_force[n]) & m_en[n];
  endfunction

  function automatic logic m_group(input int j);
    logic g = 1'b0;
    for (int n = 64 * j; n < 64 * j + 64 && n < NI; n++) g |= m_pend(n);
    return g;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = '0; m_force = '0; m_s1 = '0; m_s2 = '0;
      m_ctrl = '0; m_dis = 1'b0; e_out = '0; e_rd = '0; e_tag = "R1";
    end else begin
      int w;
      w = int'(bus_addr) / 4;
      for (int j = 0; j < NO; j++) e_out[j] = m_group(j) & !m_dis & m_ctrl[CH];
      e_rd = '0;
      e_tag = "R10";
      if (w == 0) begin
        e_rd = m_ctrl; e_tag = "R2";
      end else if (w >= 1 && w <= NB) begin
        for (int b = 0; b < 32; b++) e_rd[b] = m_en[32 * (NB - w) + b];
        e_tag = "R2";
      end else if (w > NB && w <= 2 * NB) begin
        for (int b = 0; b < 32; b++) e_rd[b] = m_force[32 * (2 * NB - w) + b];
        e_tag = "R2";
      end else if (w > 2 * NB && w <= 3 * NB) begin
        for (int b = 0; b < 32; b++) e_rd[b] = m_pend(32 * (3 * NB - w) + b);
        e_tag = "R4";
      end else if (w == 3 * NB + 1) begin
        e_rd = {31'd0, m_dis}; e_tag = "R2";
      end else if (w == 3 * NB + 2) begin
        for (int j = 0; j < NO; j++) e_rd[j] = m_group(j);
        e_tag = "R9";
      end
      if (bus_we) begin
        if (w == 0) m_ctrl = bus_wdata;
        else if (w >= 1 && w <= NB)
          for (int b = 0; b < 32; b++) m_en[32 * (NB - w) + b] = bus_wdata[b];
        else if (w > NB && w <= 2 * NB)
          for (int b = 0; b < 32; b++) m_force[32 * (2 * NB - w) + b] = bus_wdata[b];
        else if (w == 3 * NB + 1) m_dis = bus_wdata[0];
      end
      m_s2 = m_s1;
      m_s1 = irq_in;
    end
    started = 1'b1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check("R6", 32'(irq_out), 32'(e_out));
      check(e_tag, bus_rdata, e_rd);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  // byte offsets for NB = 4
  localparam logic [AW-1:0] A_CTRL = 12'h000;
  localparam logic [AW-1:0] A_EN0  = 12'h004;
  localparam logic [AW-1:0] A_EN3  = 12'h010;
  localparam logic [AW-1:0] A_FRC3 = 12'h020;
  localparam logic [AW-1:0] A_ST0  = 12'h024;
  localparam logic [AW-1:0] A_ST3  = 12'h030;
  localparam logic [AW-1:0] A_DIS  = 12'h034;
  localparam logic [AW-1:0] A_SUM  = 12'h038;
  localparam logic [AW-1:0] A_HOLE = 12'h03C;

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 32'(irq_out), 32'd0);
    rd(A_EN0, 32'd0, "R1");
    rd(A_CTRL, 32'd0, "R1");

    wr(A_CTRL, 32'h2);
    rd(A_CTRL, 32'h2, "R2");
    wr(A_DIS, 32'hFFFF_FFFF);
    rd(A_DIS, 32'h1, "R2");
    wr(A_DIS, 32'h0);

    wr(A_EN3, 32'h1);
    irq_in[0] = 1'b1;
    idle(4);
    rd(A_ST3, 32'h1, "R3");
    rd(A_ST0, 32'h0, "R3");
    check("R6", 32'(irq_out), 32'h1);
    irq_in[0] = 1'b0;
    idle(4);
    rd(A_ST3, 32'h0, "R4");

    wr(A_FRC3, 32'h1);
    idle(1);
    check("R5", 32'(irq_out), 32'h1);
    rd(A_ST3, 32'h1, "R5");
    wr(A_FRC3, 32'h0);
    idle(1);
    check("R5", 32'(irq_out), 32'h0);

    wr(A_EN0, 32'h8000_0000);
    irq_in[127] = 1'b1;
    idle(4);
    check("R6", 32'(irq_out), 32'h2);
    rd(A_ST0, 32'h8000_0000, "R3");

    wr(A_CTRL, 32'h1);
    idle(2);
    check("R7", 32'(irq_out), 32'h0);
    rd(A_SUM, 32'h2, "R9");
    wr(A_CTRL, 32'h2);

    wr(A_DIS, 32'h1);
    idle(2);
    check("R8", 32'(irq_out), 32'h0);
    rd(A_ST0, 32'h8000_0000, "R8");
    rd(A_SUM, 32'h2, "R8");
    wr(A_DIS, 32'h0);
    idle(2);
    check("R8", 32'(irq_out), 32'h2);

    wr(A_ST0, 32'h0);
    wr(A_SUM, 32'hFFFF_FFFF);
    wr(A_HOLE, 32'hFFFF_FFFF);
    rd(A_HOLE, 32'h0, "R10");
    rd(12'h100, 32'h0, "R10");
    rd(A_EN0, 32'h8000_0000, "R10");
    rd(A_ST0, 32'h8000_0000, "R10");

    irq_in[5] = 1'b1;
    idle(4);
    rd(A_ST3, 32'h0, "R4");

    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 32'(irq_out), 32'd0);
    rd(A_EN0, 32'd0, "R1");
    idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule